// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a byte-addressed slave on a two-wire (I2C-style) bus. It sits in front of a 256-entry byte array. The block runs on a system clock that oversamples the bus lines. It recognises START, repeated START and STOP conditions and decodes the control byte. It drives an open-drain enable on the data line to acknowledge bytes and to shift out read data.

Writes leave the block as single-cycle request strobes to an external write controller. Reads come from a synchronous memory port with one cycle of latency. An internal address pointer keeps its value between transactions, so byte writes, multi-byte writes, current-address reads, random reads (a write of the address only, then a repeated START) and sequential reads all work. The controller reports a busy flag. While that flag is set, the control byte is not acknowledged, so a master can poll until the write completes.

The state machine has these states:
- `S_IDLE`: ignores the bus.
- `S_CTRL`: shifts in the control byte.
- `S_CTRL_ACK`: drives the ack for the control byte.
- `S_ADDR`: shifts in the word address.
- `S_ADDR_ACK`: drives the ack for the word address.
- `S_WDATA`: shifts in a data byte.
- `S_WDATA_ACK`: drives the ack for a data byte.
- `S_RDATA`: shifts a byte out.
- `S_RACK`: samples the master's ack.

Its transitions are:
- START moves any state to `S_CTRL`.
- STOP moves any state to `S_IDLE`.
- At the end of the control byte, a match goes to `S_CTRL_ACK`. A mismatch or busy goes to `S_IDLE`.
- `S_CTRL_ACK` goes to `S_RDATA` for a read and to `S_ADDR` for a write.
- `S_ADDR` goes to `S_ADDR_ACK`, which goes to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK` alternate, one pair per byte.
- `S_RDATA` goes to `S_RACK`.
- `S_RACK` returns to `S_RDATA` on a master ack and goes to `S_IDLE` on a master NACK.

Top module: `twowire_mem_slave`

## Requirements
- R1: The control byte is taken MSB first. Bits 7..4 must equal 1010. Bits 3..1 must equal `dev_sel_i`. Bit 0 gives the direction, with 1 meaning read. When it matches and `wr_busy_i` is low, the slave pulls SDA low during the ninth clock.
- R2: If the code or the select bits differ, the slave leaves SDA released and ignores every later byte until the next START.
- R3: In a write, the first byte after the control byte loads the pointer and is acknowledged. Each later byte is acknowledged and issues exactly one single-cycle `wr_req_o`, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pointer then increments.
- R4: A random read returns the byte at the address just loaded. A random read is a control byte with the write direction, then the address byte, then a repeated START, then a control byte with the read direction.
- R5: Each byte read returns the memory byte at the pointer, MSB first, and the pointer then increments. The increment from FFh wraps to 00h.
- R6: Between transactions the pointer holds the last accessed address plus one. A current-address read returns the byte there.
- R7: In a read, a master ack (SDA low in the ninth clock) makes the slave send the next byte. A master NACK releases SDA, and the slave stays released until the next START.
- R8: While `wr_busy_i` is high at the end of the control byte, the slave does not acknowledge it.
- R9: A START or STOP in the middle of a byte abandons that byte and clears the bit count. STOP returns to idle without any write. START begins a new control byte.
- R10: After reset, SDA is released, no write strobe is raised and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_sel_i | input | 3 | Strapped device-select value |
| wr_busy_i | input | 1 | Write controller is completing a write |
| wr_req_o | output | 1 | Single-cycle write request |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 8 | Read address (current pointer) |
| rd_data_i | input | 8 | Read data, valid one clock after `rd_addr_o` |

## Verification
The bench applies several bus patterns:
- A correct control byte, a byte with the wrong select bits and a byte with the wrong code. These separate a match from a mismatch by the ack bit and by the absence of any later ack or write.
- A single-byte write followed by a current-address read, and a multi-byte write followed by a random sequential read. Together they show how the pointer loads, increments and carries over between transactions.
- A read across FFh, which checks the wrap.
- The busy flag during the control byte, and STOPs and STARTs in the middle of a byte. These show that polling and abort leave no stray write and leave the pointer where the requirements place it.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RESET_VAL;
                end else begin
                    if (g == 0) chain[g] <= d_i;
                    else        chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tws_busdet.sv
module tws_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
    assign sda_bit   =  sda_s;

    // R9
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
    import tws_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         SEL_W     = 3,
    parameter int         CODE_W    = 4,
    parameter logic [3:0] CTRL_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [SEL_W-1:0]  dev_sel_i,
    input  logic              wr_busy_i,
    output logic              sda_oe_o,
    output logic              wr_req_o,
    output logic [DATA_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

    tws_state_e        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr, tx_sr, ptr;
    logic              is_read, mack;
    logic              byte_done, ctrl_ok, rx_state;

    assign byte_done = (bit_cnt == LAST_CNT);
    assign ctrl_ok   = (rx_sr[DATA_W-1 -: CODE_W] == CTRL_CODE[CODE_W-1:0])
                     && (rx_sr[SEL_W:1] == dev_sel_i) && !wr_busy_i;
    assign rx_state  = (state == S_CTRL) || (state == S_ADDR) || (state == S_WDATA);

    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_CTRL;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_CTRL:      if (scl_fall && byte_done) nxt = ctrl_ok ? S_CTRL_ACK : S_IDLE;
                S_CTRL_ACK:  if (scl_fall) nxt = is_read ? S_RDATA : S_ADDR;
                S_ADDR:      if (scl_fall && byte_done) nxt = S_ADDR_ACK;
                S_ADDR_ACK:  if (scl_fall) nxt = S_WDATA;
                S_WDATA:     if (scl_fall && byte_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_RDATA:     if (scl_fall && byte_done) nxt = S_RACK;
                S_RACK:      if (scl_fall) nxt = mack ? S_RDATA : S_IDLE;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            mack      <= 1'b0;
            wr_req_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_req_o <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sr   <= {rx_sr[DATA_W-2:0], sda_bit};
                end else if (scl_fall && byte_done) begin
                    bit_cnt <= '0;
                    if (state == S_CTRL) begin
                        is_read <= rx_sr[0];
                    end else if (state == S_ADDR) begin
                        ptr <= rx_sr;
                    end else begin
                        wr_req_o  <= 1'b1;
                        wr_addr_o <= ptr;
                        wr_data_o <= rx_sr;
                        ptr       <= ptr + 1'b1;
                    end
                end
            end else if (state == S_CTRL_ACK) begin
                if (scl_fall && is_read) tx_sr <= rd_data_i;
            end else if (state == S_RDATA) begin
                if (scl_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (byte_done) begin
                        bit_cnt <= '0;
                        ptr     <= ptr + 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                    end
                end
            end else if (state == S_RACK) begin
                if (scl_rise) mack <= ~sda_bit;
                else if (scl_fall && mack) tx_sr <= rd_data_i;
            end
        end
    end

    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state)
            S_CTRL_ACK, S_ADDR_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_RDATA:                             sda_oe_o = ~tx_sr[DATA_W-1];
            default:                             sda_oe_o = 1'b0;
        endcase
    end

    assign rd_addr_o = ptr;

    // R9
    start_enters_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == S_CTRL && bit_cnt == '0));

    // R9
    stop_enters_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !sda_oe_o));

    // R3
    wr_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !wr_req_o);

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CTRL_ACK && $past(state) == S_CTRL) |-> !$past(wr_busy_i));

    // R5
    read_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && $past(state) == S_RDATA) |-> ptr == $past(ptr) + 1'b1);

    // R1
    sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
    parameter int         DATA_W      = 8,
    parameter int         SEL_W       = 3,
    parameter int         CODE_W      = 4,
    parameter logic [3:0] CTRL_CODE   = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [SEL_W-1:0]  dev_sel_i,
    input  logic              wr_busy_i,
    output logic              wr_req_o,
    output logic [DATA_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, sync_lines;
    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            tws_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d_i  (raw_lines[l]),
                .q_o  (sync_lines[l])
            );
        end
    endgenerate

    tws_busdet u_busdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (sync_lines[1]),
        .sda_s    (sync_lines[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (sda_bit)
    );

    tws_fsm #(
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .CODE_W   (CODE_W),
        .CTRL_CODE(CTRL_CODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (sync_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (sda_bit),
        .dev_sel_i(dev_sel_i),
        .wr_busy_i(wr_busy_i),
        .sda_oe_o (sda_oe_o),
        .wr_req_o (wr_req_o),
        .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o),
        .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i)
    );
endmodule

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
    localparam int Q = 20;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, wr_busy = 1'b0, wr_req;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    int checks = 0, errors = 0, wr_count = 0;
    bit finished = 1'b0;
    logic sda_line;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    twowire_mem_slave u_twowire_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .dev_sel_i(SEL), .wr_busy_i(wr_busy),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_req) begin
            mem[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2);
        acked = ~sda_line; tick(Q/2); m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_scl = 1'b1; tick(Q/2); b[i] = sda_line;
            tick(Q/2); m_scl = 1'b0;
        end
        tick(Q/2); m_sda = ~give_ack; tick(Q/2);
        m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q/2); m_sda = 1'b1; tick(Q/2);
    endtask

    task automatic t_reset;
        check(sda_oe == 1'b0, "R10", "sda released after reset", sda_oe, 0);
        check(wr_req == 1'b0, "R10", "no write after reset", wr_req, 0);
        check(rd_addr == 8'h00, "R10", "pointer after reset", rd_addr, 0);
    endtask

    task automatic t_byte_write_then_current_read;
        bit a; logic [7:0] d; int base = wr_count;
        bus_start;
        send_byte({4'b1010, SEL, 1'b0}, a); check(a, "R1", "control ack", a, 1);
        send_byte(8'h10, a); check(a, "R3", "address ack", a, 1);
        send_byte(8'hA5, a); check(a, "R3", "data ack", a, 1);
        bus_stop; ref_mem[8'h10] = 8'hA5;
        check(wr_count == base + 1, "R3", "one write strobe", wr_count - base, 1);
        check(mem[8'h10] == 8'hA5, "R3", "written byte", mem[8'h10], 8'hA5);
        bus_start;
        send_byte({4'b1010, SEL, 1'b1}, a); check(a, "R1", "read control ack", a, 1);
        recv_byte(1'b0, d); bus_stop;
        check(d == ref_mem[8'h11], "R6", "current-address read", d, ref_mem[8'h11]);
    endtask

    task automatic t_multi_write_random_read;
        bit a; logic [7:0] d; int base = wr_count;
        bus_start;
        send_byte({4'b1010, SEL, 1'b0}, a);
        send_byte(8'h40, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hC0 + 8'(i), a); ref_mem[8'h40 + i] = 8'hC0 + 8'(i);
        end
        bus_stop;
        check(wr_count == base + 3, "R3", "three write strobes", wr_count - base, 3);
        bus_start;
        send_byte({4'b1010, SEL, 1'b0}, a); send_byte(8'h40, a);
        bus_start;
        send_byte({4'b1010, SEL, 1'b1}, a); check(a, "R4", "repeated start ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i != 2, d);
            check(d == ref_mem[8'h40 + i], "R4", "random/sequential read", d, ref_mem[8'h40 + i]);
        end
        check(sda_oe == 1'b0, "R7", "released after master NACK", sda_oe, 0);
        bus_stop;
    endtask

    task automatic t_wrap;
        bit a; logic [7:0] d; logic [7:0] ad;
        bus_start;
        send_byte({4'b1010, SEL, 1'b0}, a); send_byte(8'hFE, a);
        bus_start; send_byte({4'b1010, SEL, 1'b1}, a);
        for (int i = 0; i < 3; i++) begin
            ad = 8'hFE + 8'(i);
            recv_byte(i != 2, d);
            check(d == ref_mem[ad], "R5", "read across wrap", d, ref_mem[ad]);
        end
        bus_stop;
        check(rd_addr == 8'h01, "R5", "pointer after wrap", rd_addr, 1);
    endtask

    task automatic t_mismatch;
        bit a; int base = wr_count;
        bus_start;
        send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, a); check(!a, "R2", "wrong select nack", a, 0);
        send_byte(8'h20, a); check(!a, "R2", "ignored byte after mismatch", a, 0);
        send_byte(8'h55, a); bus_stop;
        check(wr_count == base, "R2", "no write after mismatch", wr_count - base, 0);
        bus_start;
        send_byte({4'b0110, SEL, 1'b0}, a); check(!a, "R1", "wrong code nack", a, 0);
        bus_stop;
    endtask

    task automatic t_busy;
        bit a;
        wr_busy = 1'b1;
        bus_start; send_byte({4'b1010, SEL, 1'b0}, a); bus_stop;
        check(!a, "R8", "no ack while busy", a, 0);
        wr_busy = 1'b0;
        bus_start; send_byte({4'b1010, SEL, 1'b0}, a); bus_stop;
        check(a, "R8", "ack after busy clears", a, 1);
    endtask

    task automatic t_abort;
        bit a; logic [7:0] d; int base = wr_count;
        bus_start;
        send_byte({4'b1010, SEL, 1'b0}, a); send_byte(8'h30, a);
        send_bits(8'hFF, 4); bus_stop;
        check(wr_count == base, "R9", "stop mid-byte writes nothing", wr_count - base, 0);
        bus_start; send_bits({4'b1010, SEL, 1'b0}, 3);
        bus_start; send_byte({4'b1010, SEL, 1'b1}, a);
        check(a, "R9", "restart mid-byte then control ack", a, 1);
        recv_byte(1'b0, d); bus_stop;
        check(d == ref_mem[8'h30], "R9", "pointer after abort", d, ref_mem[8'h30]);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h3C;
            ref_mem[i] = 8'(i) ^ 8'h3C;
        end
        tick(5); rst_n = 1'b1; tick(5);
        t_reset;
        t_byte_write_then_current_read;
        t_multi_write_random_read;
        t_wrap;
        t_mismatch;
        t_busy;
        t_abort;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule